// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This block is a pipeline stage placed between instruction decode and issue. It takes one decoded scalar operation, with destination index RT, source indices RA and RB, and one flag per operand that marks it as a vector or a scalar. It replays that operation as a hardware for-loop. Each cycle it sends one element-level scalar operation to the issue stage over a valid/ready handshake. On every element, each operand flagged as a vector has its register index stepped up by one.

While a loop is running, the block holds the main program counter with a stall output, so that the element operations appear in the same order an unrolled scalar sequence would have. The loop count comes from a small vector-length register. A set-length request writes that register. Register indices are 7 bits wide, which addresses register files of 128 entries. An index that runs past the top of the file wraps, and a sticky flag records that it happened.

Top module: `vec_elem_seq`

## Requirements
- R1: `in_ready` is high exactly when no loop is running. An operation presented with `in_valid` while `in_ready` is high is accepted at that clock edge, and when it issues anything, its element 0 is on the outputs in the next cycle.
- R2: `pc_stall` is high from the cycle after an issuing operation is accepted up to and including the cycle of its final element handshake. It is low in the following cycle.
- R3: For an operand flagged as a vector, the index sent with element e is (base + e) mod 128, on the 7-bit `out_rt`, `out_ra` and `out_rb` buses.
- R4: Elements are issued strictly in order 0, 1, …, N−1. `out_elem` carries the element number, and `out_last` is high only on element N−1. N is the vector length when any operand is a vector, and 1 when none is.
- R5: An operand flagged as scalar keeps its base index on every element. An operation with all three flags clear issues exactly once, whatever the vector length is.
- R6: While `out_valid` is high and `out_ready` is low, the element operation on the outputs stays unchanged and the element number does not advance.
- R7: An operation with at least one vector operand is accepted when the vector length is 0. It issues no element, it does not raise `pc_stall`, and `in_ready` stays high.
- R8: `range_err` goes high after an element is handed over in which some vector operand had base + e > 127. It then stays high until reset.
- R9: A set-length request made while no loop runs takes effect at that clock edge. A request made while a loop runs leaves the current loop's length unchanged and applies to the operations that follow.
- R10: After reset, `out_valid`, `pc_stall` and `range_err` are low, `in_ready` is high, and the vector length is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded operation offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_opc | input | 8 | Opaque operation code, passed through |
| in_rt | input | 7 | Destination base index |
| in_ra | input | 7 | First source base index |
| in_rb | input | 7 | Second source base index |
| in_rt_vec | input | 1 | Destination is a vector operand |
| in_ra_vec | input | 1 | First source is a vector operand |
| in_rb_vec | input | 1 | Second source is a vector operand |
| setvl_valid | input | 1 | Set-vector-length request |
| setvl_len | input | 8 | New vector length |
| out_valid | output | 1 | Element operation offered to issue |
| out_ready | input | 1 | Issue stage takes the element |
| out_opc | output | 8 | Operation code of the element |
| out_rt | output | 7 | Element destination index |
| out_ra | output | 7 | Element first source index |
| out_rb | output | 7 | Element second source index |
| out_elem | output | 8 | Element number within the loop |
| out_last | output | 1 | Final element of the loop |
| pc_stall | output | 1 | Hold the program counter |
| range_err | output | 1 | Sticky index-wrap flag |

## Verification
If the element counter is corrupted, the effect shows up in the very next offered element: `out_elem` and every vector index step by the wrong amount or skip a value. A fault in the loop-end decision shows up one cycle after the last element, as `pc_stall` and `out_valid` staying high or falling too early, and it also shifts the element count of every later operation. A length write applied at the wrong moment changes the number of elements issued, either in the running loop or in the next operation. A wrong wrap detection leaves `range_err` wrong one cycle after the offending handover, and that error persists until reset. The bench exercises back-pressure, scalar-only operations, a length of zero, index wrap and writes made in the middle of a loop, and it checks every offered element against a model.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int IDX_W    = 7;
    localparam int VL_W     = 8;
    localparam int OPC_W    = 8;
    localparam int NUM_OPS  = 3;   // 0: RT, 1: RA, 2: RB
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int SUM_W    = ((IDX_W > VL_W) ? IDX_W : VL_W) + 1;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [VL_W-1:0]  vl_t;
    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [SUM_W-1:0] sum_t;

    localparam vl_t  VL_RESET  = vl_t'(1);
    localparam sum_t SUM_LIMIT = sum_t'(NUM_REGS);

    typedef struct packed {
        logic is_vec;
        idx_t base;
    } operand_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOOP = 1'b1
    } seq_state_e;

    // Unwrapped index of an operand for a given element number.
    function automatic sum_t raw_index(operand_t op, vl_t e);
        sum_t step;
        step = op.is_vec ? sum_t'(e) : '0;
        return sum_t'(op.base) + step;
    endfunction
endpackage

// File: rtl/vseq_vl_reg.sv
module vseq_vl_reg
    import vseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic wr_valid,
    input  vl_t  wr_len,
    output vl_t  vl_q,
    output vl_t  vl_eff
);
    logic pend_v;
    vl_t  pend_len;

    // Length seen by an operation accepted in this cycle.
    always_comb begin
        if (!busy && wr_valid)
            vl_eff = wr_len;
        else if (!busy && pend_v)
            vl_eff = pend_len;
        else
            vl_eff = vl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q     <= VL_RESET;
            pend_v   <= 1'b0;
            pend_len <= '0;
        end else if (wr_valid && busy) begin
            pend_v   <= 1'b1;
            pend_len <= wr_len;
        end else if (!busy) begin
            vl_q   <= vl_eff;
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/vseq_idx_gen.sv
module vseq_idx_gen
    import vseq_pkg::*;
(
    input  operand_t [NUM_OPS-1:0] ops,
    input  vl_t                    elem,
    output idx_t     [NUM_OPS-1:0] idx,
    output logic                   any_ovf
);
    logic [NUM_OPS-1:0] ovf;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
        sum_t sum;
        assign sum    = raw_index(ops[g], elem);
        assign idx[g] = sum[IDX_W-1:0];
        assign ovf[g] = (sum >= SUM_LIMIT);
    end

    assign any_ovf = |ovf;
endmodule

// File: rtl/vseq_loop_ctrl.sv
module vseq_loop_ctrl
    import vseq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  opc_t                   in_opc,
    input  operand_t [NUM_OPS-1:0] in_ops,
    input  vl_t                    vl_eff,
    input  vl_t                    vl_q,
    input  logic                   out_ready,
    input  logic                   elem_ovf,
    output logic                   in_ready,
    output logic                   busy,
    output logic                   last,
    output vl_t                    elem,
    output opc_t                   opc_q,
    output operand_t [NUM_OPS-1:0] ops_q,
    output logic                   range_err
);
    seq_state_e state_q;
    logic       any_vec_in;
    logic       any_vec_q;
    logic       accept;
    logic       start;
    logic       fire;

    always_comb begin
        any_vec_in = 1'b0;
        for (int i = 0; i < NUM_OPS; i++)
            any_vec_in = any_vec_in | in_ops[i].is_vec;
    end

    assign in_ready = (state_q == ST_IDLE);
    assign busy     = (state_q == ST_LOOP);
    assign accept   = in_valid && in_ready;
    assign start    = accept && !(any_vec_in && (vl_eff == '0));
    assign fire     = busy && out_ready;
    assign last     = any_vec_q ? (elem == vl_t'(vl_q - vl_t'(1))) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elem      <= '0;
            opc_q     <= '0;
            ops_q     <= '0;
            any_vec_q <= 1'b0;
            range_err <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        opc_q     <= in_opc;
                        ops_q     <= in_ops;
                        any_vec_q <= any_vec_in;
                        elem      <= '0;
                    end
                    if (start)
                        state_q <= ST_LOOP;
                end
                ST_LOOP: begin
                    if (fire) begin
                        if (last)
                            state_q <= ST_IDLE;
                        else
                            elem <= elem + vl_t'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (fire && elem_ovf)
                range_err <= 1'b1;
        end
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPC_W-1:0] in_opc,
    input  logic [IDX_W-1:0] in_rt,
    input  logic [IDX_W-1:0] in_ra,
    input  logic [IDX_W-1:0] in_rb,
    input  logic             in_rt_vec,
    input  logic             in_ra_vec,
    input  logic             in_rb_vec,
    input  logic             setvl_valid,
    input  logic [VL_W-1:0]  setvl_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OPC_W-1:0] out_opc,
    output logic [IDX_W-1:0] out_rt,
    output logic [IDX_W-1:0] out_ra,
    output logic [IDX_W-1:0] out_rb,
    output logic [VL_W-1:0]  out_elem,
    output logic             out_last,
    output logic             pc_stall,
    output logic             range_err
);
    operand_t [NUM_OPS-1:0] in_ops;
    operand_t [NUM_OPS-1:0] ops_q;
    idx_t     [NUM_OPS-1:0] idx;
    vl_t                    vl_q;
    vl_t                    vl_eff;
    vl_t                    elem;
    logic                   busy;
    logic                   elem_ovf;

    assign in_ops[0] = '{is_vec: in_rt_vec, base: in_rt};
    assign in_ops[1] = '{is_vec: in_ra_vec, base: in_ra};
    assign in_ops[2] = '{is_vec: in_rb_vec, base: in_rb};

    vseq_vl_reg u_vl (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .wr_valid (setvl_valid),
        .wr_len   (setvl_len),
        .vl_q     (vl_q),
        .vl_eff   (vl_eff)
    );

    vseq_loop_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_opc    (in_opc),
        .in_ops    (in_ops),
        .vl_eff    (vl_eff),
        .vl_q      (vl_q),
        .out_ready (out_ready),
        .elem_ovf  (elem_ovf),
        .in_ready  (in_ready),
        .busy      (busy),
        .last      (out_last),
        .elem      (elem),
        .opc_q     (out_opc),
        .ops_q     (ops_q),
        .range_err (range_err)
    );

    vseq_idx_gen u_idx (
        .ops     (ops_q),
        .elem    (elem),
        .idx     (idx),
        .any_ovf (elem_ovf)
    );

    assign out_valid = busy;
    assign pc_stall  = busy;
    assign out_elem  = elem;
    assign out_rt    = idx[0];
    assign out_ra    = idx[1];
    assign out_rb    = idx[2];
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker
    import vseq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input idx_t out_rt,
    input idx_t out_ra,
    input idx_t out_rb,
    input vl_t  out_elem,
    input logic out_last,
    input logic pc_stall,
    input logic range_err
);
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(pc_stall) |-> $past(out_valid && out_ready && out_last)); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rt) && $stable(out_ra)
                                       && $stable(out_rb) && $stable(out_elem))); // R6

    AST_ELEM_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
            (out_valid && out_elem == vl_t'($past(out_elem) + vl_t'(1)))); // R4

    AST_RT_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
            (out_rt == $past(out_rt) || out_rt == idx_t'($past(out_rt) + idx_t'(1)))); // R3

    AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        range_err |=> range_err); // R8

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(pc_stall) |-> in_ready); // R1
endmodule

bind vec_elem_seq vseq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rt    (out_rt),
    .out_ra    (out_ra),
    .out_rb    (out_rb),
    .out_elem  (out_elem),
    .out_last  (out_last),
    .pc_stall  (pc_stall),
    .range_err (range_err)
);

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_opc = '0;
    logic [6:0] in_rt = '0, in_ra = '0, in_rb = '0;
    logic       in_rt_vec = 1'b0, in_ra_vec = 1'b0, in_rb_vec = 1'b0;
    logic       setvl_valid = 1'b0;
    logic [7:0] setvl_len = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_opc;
    logic [6:0] out_rt, out_ra, out_rb;
    logic [7:0] out_elem;
    logic       out_last, pc_stall, range_err;

    int checks = 0;
    int errors = 0;
    int vl_model = 1;
    bit range_model = 1'b0;

    always #5 clk = ~clk;

    vec_elem_seq u_vec_elem_seq (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_idx(input int base, input bit v, input int e);
        return (base + (v ? e : 0)) % 128;
    endfunction

    task automatic set_vl(input int len);
        @(negedge clk);
        setvl_valid = 1'b1;
        setvl_len   = 8'(len);
        @(negedge clk);
        setvl_valid = 1'b0;
        vl_model    = len;
    endtask

    // Offer one operation and follow every element it produces.
    task automatic run_op(input int opc, input int rt, input int ra, input int rb,
                          input bit vt, input bit va, input bit vb,
                          input int ready_pct, input int mid_len);
        int  count;
        int  e;
        bit  rdy;
        bit  prev_hold;
        bit  wrote;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready when idle", int'(in_ready), 1);
        in_valid  = 1'b1;
        in_opc    = 8'(opc);
        in_rt = 7'(rt); in_ra = 7'(ra); in_rb = 7'(rb);
        in_rt_vec = vt; in_ra_vec = va; in_rb_vec = vb;
        out_ready = 1'b0;
        count = (vt || va || vb) ? vl_model : 1;
        @(negedge clk);
        in_valid = 1'b0;
        if (count == 0) begin
            check(out_valid == 1'b0, "R7", "no element for zero length", int'(out_valid), 0);
            check(pc_stall == 1'b0, "R7", "no stall for zero length", int'(pc_stall), 0);
            check(in_ready == 1'b1, "R7", "ready after zero length", int'(in_ready), 1);
            return;
        end
        e = 0;
        prev_hold = 1'b0;
        wrote = 1'b0;
        while (e < count) begin
            check(out_valid == 1'b1, "R1", "element offered", int'(out_valid), 1);
            check(pc_stall == 1'b1, "R2", "stall during loop", int'(pc_stall), 1);
            check(out_elem == 8'(e), prev_hold ? "R6" : "R4", "element number", int'(out_elem), e);
            check(out_last == (e == count - 1), "R4", "last flag", int'(out_last),
                  int'(e == count - 1));
            check(out_opc == 8'(opc), "R4", "opcode", int'(out_opc), opc);
            check(out_rt == 7'(exp_idx(rt, vt, e)), vt ? "R3" : "R5", "rt index",
                  int'(out_rt), exp_idx(rt, vt, e));
            check(out_ra == 7'(exp_idx(ra, va, e)), va ? "R3" : "R5", "ra index",
                  int'(out_ra), exp_idx(ra, va, e));
            check(out_rb == 7'(exp_idx(rb, vb, e)), vb ? "R3" : "R5", "rb index",
                  int'(out_rb), exp_idx(rb, vb, e));
            rdy = (($urandom % 100) < ready_pct);
            out_ready = rdy;
            if (mid_len >= 0 && !wrote) begin
                setvl_valid = 1'b1;
                setvl_len   = 8'(mid_len);
                wrote = 1'b1;
            end
            @(negedge clk);
            setvl_valid = 1'b0;
            prev_hold = !rdy;
            if (rdy) begin
                if ((vt && rt + e > 127) || (va && ra + e > 127) || (vb && rb + e > 127))
                    range_model = 1'b1;
                e++;
            end
        end
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R2", "valid drops after last", int'(out_valid), 0);
        check(pc_stall == 1'b0, "R2", "stall released after last", int'(pc_stall), 0);
        check(range_err == range_model, "R8", "range flag", int'(range_err), int'(range_model));
        if (wrote)
            vl_model = mid_len;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
        check(pc_stall == 1'b0, "R10", "pc_stall after reset", int'(pc_stall), 0);
        check(range_err == 1'b0, "R10", "range_err after reset", int'(range_err), 0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
        // R10: reset length of 1 gives one element
        run_op(8'h11, 5, 6, 7, 1, 1, 1, 100, -1);
        // R3, R5: mixed flags
        set_vl(4);
        run_op(8'h22, 10, 20, 30, 1, 0, 1, 100, -1);
        // R5: scalar-only operation issues once
        run_op(8'h33, 1, 2, 3, 0, 0, 0, 100, -1);
        // R6: back-pressure
        set_vl(6);
        run_op(8'h44, 40, 50, 60, 1, 1, 0, 35, -1);
        // R7: zero length, then a scalar op still issues once
        set_vl(0);
        run_op(8'h55, 8, 9, 10, 0, 1, 0, 100, -1);
        run_op(8'h56, 8, 9, 10, 0, 0, 0, 100, -1);
        // R9: write during a loop is deferred
        set_vl(5);
        run_op(8'h66, 0, 1, 2, 1, 1, 1, 60, 3);
        run_op(8'h67, 3, 4, 5, 1, 0, 0, 100, -1);
        // R8: wrap and sticky flag
        set_vl(8);
        run_op(8'h77, 124, 0, 7, 1, 0, 0, 100, -1);
        run_op(8'h78, 0, 1, 2, 1, 1, 1, 100, -1);
        // Random mix
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 3) == 0)
                set_vl(int'($urandom % 13));
            run_op(int'($urandom % 256), int'($urandom % 128), int'($urandom % 128),
                   int'($urandom % 128), bit'($urandom % 2), bit'($urandom % 2),
                   bit'($urandom % 2), 30 + int'($urandom % 71),
                   (($urandom % 4) == 0) ? int'($urandom % 13) : -1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule